// File: doc/BRIEF.md
# Two-Level Segment and Page Address Translator

This block converts a 34-bit two-part virtual word address into a 24-bit physical word address. The upper 18 bits name a segment and the lower 16 bits give a word offset inside it. The offset is further split into a 6-bit page index and a 10-bit word-within-page field. The translation uses three memory reads through a single-port read interface. The first read goes to the page table of the descriptor segment, which a base pointer input locates. The second read fetches the segment's descriptor. The third read fetches the page table entry of the addressed page.

Each walk ends in one of two ways. It returns the physical address, or it stops early with a fault code: segment fault, protection fault or page fault. The requester offers one address at a time with a valid/ready handshake and receives a one-cycle done strobe. The strobe carries the address and the fault code. Only one walk runs at a time. The memory returns data one cycle after a read strobe. The block latches the base pointer, the address and the access kind when it accepts a request.

Top module: `segpg_xlate`

## Requirements
- R1: `req_ready` is high exactly while no walk is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low from the next cycle until the done cycle of that walk.
- R2: In the cycle after acceptance, `mem_rd` is high and `mem_addr` = {`dbr_ptr`, 6'b0} + va[33:26]. Bit 35 of the returned word is a present flag, and bits [13:0] are a frame number.
- R3: If that entry has bit 35 clear, `rsp_done` rises 2 cycles after acceptance with `rsp_fault` = 1 (segment fault).
- R4: The descriptor is read at {frame, 10'b0} + va[25:16]. Descriptor bit 35 is the in-memory flag. If it is clear, the walk ends 4 cycles after acceptance with `rsp_fault` = 1, whatever its permission and size fields hold.
- R5: Descriptor bit 34 allows reads and bit 33 allows writes. If the bit for the requested access (`req_write`) is clear, the walk ends 4 cycles after acceptance with `rsp_fault` = 2.
- R6: Descriptor bits [28:18] give the segment size in 64-word blocks, from 0 to 1024. If va[15:6] is at or above that size, the walk ends 4 cycles after acceptance with `rsp_fault` = 2.
- R7: The page table entry is read at {descriptor bits [17:0], 6'b0} + va[15:10]. If its bit 35 is clear, the walk ends 6 cycles after acceptance with `rsp_fault` = 3 (page fault).
- R8: If that entry is present, the walk ends 6 cycles after acceptance with `rsp_fault` = 0 and `rsp_paddr` = {entry bits [13:0], 10'b0} + va[9:0].
- R9: `rsp_done` is a single-cycle pulse. When it comes with a nonzero fault code, `rsp_paddr` is zero.
- R10: While `rst_n` is low, `req_ready` is high and `rsp_done` and `mem_rd` are low.
- R11: `req_valid` pulses that arrive while a walk is in progress are ignored. They cause no extra memory read and do not alter the running walk's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbr_ptr | input | 18 | Descriptor-segment page table pointer (64-word aligned) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_vaddr | input | 34 | Virtual address {segment, page, word} |
| req_write | input | 1 | 1 = store access, 0 = load access |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_paddr | output | 24 | Physical word address (zero on fault) |
| rsp_fault | output | 2 | 0 none, 1 segment, 2 protection, 3 page |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 24 | Memory read address |
| mem_rdata | input | 36 | Read data, valid the cycle after the strobe |

## Verification
The completion strobe of one walk and the acceptance of the next request can fall in the same cycle, because `req_ready` is already high while `rsp_done` is shown. The bench provokes this by keeping `req_valid` high with a second address while the first walk is still running. The behavioural model then expects the first result on the done cycle and a new read strobe, at the second request's descriptor-table address, in the very next cycle. Busy-time pulses carrying a different, faulting address check the opposite case: the model expects neither a read nor a response from them.

// File: rtl/segpg_pkg.sv
// Shared widths, field positions and encodings for the segment/page translator.
// Assumes 36-bit table words and a 24-bit physical word space.
package segpg_pkg;
    localparam int SEG_W    = 18;
    localparam int OFF_W    = 16;
    localparam int WORD_W   = 10;
    localparam int PAGE_W   = OFF_W - WORD_W;
    localparam int VA_W     = SEG_W + OFF_W;
    localparam int PA_W     = 24;
    localparam int PTR_W    = 18;
    localparam int ALIGN_W  = PA_W - PTR_W;
    localparam int FRAME_W  = PA_W - WORD_W;
    localparam int DW       = 36;
    localparam int DIDX_W   = 10;
    localparam int DPG_W    = SEG_W - DIDX_W;
    localparam int BLK_W    = 6;
    localparam int BIDX_W   = OFF_W - BLK_W;
    localparam int SIZE_W   = BIDX_W + 1;
    localparam int PRES_BIT = DW - 1;
    localparam int RD_BIT   = DW - 2;
    localparam int WR_BIT   = DW - 3;
    localparam int SIZE_LSB = PTR_W;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_SEG  = 2'd1,
        FLT_PROT = 2'd2,
        FLT_PAGE = 2'd3
    } fault_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DPT_RD,
        ST_DPT_CK,
        ST_DSC_RD,
        ST_DSC_CK,
        ST_PTE_RD,
        ST_PTE_CK
    } walk_st_t;
endpackage

// File: rtl/segpg_addr_gen.sv
// Builds the memory read address for the current walk stage.
// Assumes the base pointers are held stable by the walk controller.
module segpg_addr_gen
    import segpg_pkg::*;
(
    input  walk_st_t               st,
    input  logic [SEG_W-1:0]       seg,
    input  logic [PAGE_W-1:0]      page,
    input  logic [PTR_W-1:0]       dbr_q,
    input  logic [FRAME_W-1:0]     dframe_q,
    input  logic [PTR_W-1:0]       pt_ptr_q,
    output logic [PA_W-1:0]        mem_addr
);
    logic [PA_W-1:0] dpt_addr;
    logic [PA_W-1:0] dsc_addr;
    logic [PA_W-1:0] pte_addr;

    // Per-stage address: aligned base plus the stage's index field.
    always_comb begin
        dpt_addr = {dbr_q, {ALIGN_W{1'b0}}} + PA_W'(seg[SEG_W-1:DIDX_W]);
        dsc_addr = {dframe_q, {WORD_W{1'b0}}} + PA_W'(seg[DIDX_W-1:0]);
        pte_addr = {pt_ptr_q, {ALIGN_W{1'b0}}} + PA_W'(page);
    end

    // Pick the address that belongs to the active read stage.
    always_comb begin
        unique case (st)
            ST_DPT_RD, ST_DPT_CK: mem_addr = dpt_addr;
            ST_DSC_RD, ST_DSC_CK: mem_addr = dsc_addr;
            ST_PTE_RD, ST_PTE_CK: mem_addr = pte_addr;
            default:              mem_addr = dpt_addr;
        endcase
    end
endmodule

// File: rtl/segpg_desc_check.sv
// Decodes a segment descriptor and judges the access against it.
// Assumes the descriptor word is the memory data of the descriptor read.
module segpg_desc_check
    import segpg_pkg::*;
(
    input  logic [DW-1:0]      desc,
    input  logic               is_write,
    input  logic [BIDX_W-1:0]  off_blk,
    output logic               present,
    output logic               allow,
    output logic [PTR_W-1:0]   pt_ptr
);
    logic [SIZE_W-1:0] size_blk;
    logic              perm_ok;
    logic              in_range;
    logic              unused_rsvd;

    // Field extraction and the permission and size tests.
    always_comb begin
        present  = desc[PRES_BIT];
        perm_ok  = is_write ? desc[WR_BIT] : desc[RD_BIT];
        size_blk = desc[SIZE_LSB +: SIZE_W];
        in_range = {1'b0, off_blk} < size_blk;
        allow    = perm_ok && in_range;
        pt_ptr   = desc[PTR_W-1:0];
    end

    assign unused_rsvd = ^desc[WR_BIT-1:SIZE_LSB+SIZE_W];
endmodule

// File: rtl/segpg_walk_fsm.sv
// Sequences the three-read walk, holds the request and the base pointers,
// and registers the response. Assumes read data arrives one cycle after
// the strobe and that only one walk runs at a time.
module segpg_walk_fsm
    import segpg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic                req_write,
    input  logic [PTR_W-1:0]    dbr_ptr,
    input  logic [DW-1:0]       mem_rdata,
    input  logic                dsc_present,
    input  logic                dsc_allow,
    input  logic [PTR_W-1:0]    dsc_ptr,
    output walk_st_t            st,
    output logic [VA_W-1:0]     va_q,
    output logic                wr_q,
    output logic [PTR_W-1:0]    dbr_q,
    output logic [FRAME_W-1:0]  dframe_q,
    output logic [PTR_W-1:0]    pt_ptr_q,
    output logic                done_q,
    output fault_t              fault_q,
    output logic [PA_W-1:0]     paddr_q
);
    logic entry_present;
    logic unused_entry_bits;

    assign entry_present     = mem_rdata[PRES_BIT];
    assign unused_entry_bits = ^mem_rdata[PRES_BIT-1:FRAME_W];

    // Walk state, captured fields and the registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            va_q     <= '0;
            wr_q     <= 1'b0;
            dbr_q    <= '0;
            dframe_q <= '0;
            pt_ptr_q <= '0;
            done_q   <= 1'b0;
            fault_q  <= FLT_NONE;
            paddr_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q  <= req_vaddr;
                        wr_q  <= req_write;
                        dbr_q <= dbr_ptr;
                        st    <= ST_DPT_RD;
                    end
                end
                ST_DPT_RD: st <= ST_DPT_CK;
                ST_DPT_CK: begin
                    if (!entry_present) begin
                        done_q  <= 1'b1;
                        fault_q <= FLT_SEG;
                        paddr_q <= '0;
                        st      <= ST_IDLE;
                    end else begin
                        dframe_q <= mem_rdata[FRAME_W-1:0];
                        st       <= ST_DSC_RD;
                    end
                end
                ST_DSC_RD: st <= ST_DSC_CK;
                ST_DSC_CK: begin
                    if (!dsc_present || !dsc_allow) begin
                        done_q  <= 1'b1;
                        fault_q <= dsc_present ? FLT_PROT : FLT_SEG;
                        paddr_q <= '0;
                        st      <= ST_IDLE;
                    end else begin
                        pt_ptr_q <= dsc_ptr;
                        st       <= ST_PTE_RD;
                    end
                end
                ST_PTE_RD: st <= ST_PTE_CK;
                ST_PTE_CK: begin
                    done_q <= 1'b1;
                    st     <= ST_IDLE;
                    if (!entry_present) begin
                        fault_q <= FLT_PAGE;
                        paddr_q <= '0;
                    end else begin
                        fault_q <= FLT_NONE;
                        paddr_q <= {mem_rdata[FRAME_W-1:0], {WORD_W{1'b0}}}
                                   + PA_W'(va_q[WORD_W-1:0]);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/segpg_xlate.sv
// Top of the segment/page translator: handshake, walk controller, address
// generation and descriptor check. Assumes a memory with one-cycle read latency.
module segpg_xlate
    import segpg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [17:0]         dbr_ptr,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [33:0]         req_vaddr,
    input  logic                req_write,
    output logic                rsp_done,
    output logic [23:0]         rsp_paddr,
    output logic [1:0]          rsp_fault,
    output logic                mem_rd,
    output logic [23:0]         mem_addr,
    input  logic [35:0]         mem_rdata
);
    walk_st_t               st;
    logic [VA_W-1:0]        va_q;
    logic                   wr_q;
    logic [PTR_W-1:0]       dbr_q;
    logic [FRAME_W-1:0]     dframe_q;
    logic [PTR_W-1:0]       pt_ptr_q;
    logic                   dsc_present;
    logic                   dsc_allow;
    logic [PTR_W-1:0]       dsc_ptr;
    fault_t                 fault_q;

    segpg_walk_fsm u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_vaddr   (req_vaddr),
        .req_write   (req_write),
        .dbr_ptr     (dbr_ptr),
        .mem_rdata   (mem_rdata),
        .dsc_present (dsc_present),
        .dsc_allow   (dsc_allow),
        .dsc_ptr     (dsc_ptr),
        .st          (st),
        .va_q        (va_q),
        .wr_q        (wr_q),
        .dbr_q       (dbr_q),
        .dframe_q    (dframe_q),
        .pt_ptr_q    (pt_ptr_q),
        .done_q      (rsp_done),
        .fault_q     (fault_q),
        .paddr_q     (rsp_paddr)
    );

    segpg_addr_gen u_addr (
        .st       (st),
        .seg      (va_q[VA_W-1:OFF_W]),
        .page     (va_q[OFF_W-1:WORD_W]),
        .dbr_q    (dbr_q),
        .dframe_q (dframe_q),
        .pt_ptr_q (pt_ptr_q),
        .mem_addr (mem_addr)
    );

    segpg_desc_check u_chk (
        .desc     (mem_rdata),
        .is_write (wr_q),
        .off_blk  (va_q[OFF_W-1:BLK_W]),
        .present  (dsc_present),
        .allow    (dsc_allow),
        .pt_ptr   (dsc_ptr)
    );

    // Handshake and strobe decode from the walk state.
    always_comb begin
        req_ready = (st == ST_IDLE);
        mem_rd    = (st == ST_DPT_RD) || (st == ST_DSC_RD) || (st == ST_PTE_RD);
        rsp_fault = fault_q;
    end
endmodule

// File: rtl/segpg_xlate_chk.sv
// Port-level properties of the translator, bound to every instance of the top.
module segpg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_rd,
    input logic        rsp_done,
    input logic [1:0]  rsp_fault,
    input logic [23:0] rsp_paddr
);
    // R1: a taken request makes the block busy on the next cycle
    a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R1: no memory read while idle
    a_r1_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd);

    // R2: first read strobe directly after acceptance
    a_r2_read_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_rd);

    // R11: each read strobe lasts one cycle
    a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R9: a faulted response carries a zero address
    a_r9_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_fault != 2'd0) |-> (rsp_paddr == 24'd0));

    // R1: the block is idle again in its done cycle
    a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);
endmodule

bind segpg_xlate segpg_xlate_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_rd    (mem_rd),
    .rsp_done  (rsp_done),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr)
);

// File: tb/segpg_xlate_tb_top.sv
`timescale 1ns/1ps
module segpg_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] dbr_ptr = 18'h00100;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [33:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_done;
    logic [23:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_rd;
    logic [23:0] mem_addr;
    logic [35:0] mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    segpg_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .dbr_ptr(dbr_ptr),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_done(rsp_done), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    // ---------------- memory model ----------------
    logic [35:0] mem [int];

    function automatic logic [35:0] rdm(input int a);
        return mem.exists(a) ? mem[a] : 36'd0;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= rdm(int'(mem_addr));

    function automatic logic [35:0] pte(input int frame);
        return {1'b1, 21'd0, frame[13:0]};
    endfunction

    function automatic logic [35:0] dsc(input bit p, input bit r, input bit w,
                                        input int size, input int ptr);
        return {p, r, w, 4'd0, size[10:0], ptr[17:0]};
    endfunction

    // ---------------- reference model ----------------
    bit          exp_ready = 1'b1;
    bit          exp_done  = 1'b0;
    int          cnt = 0;
    bit          pending = 1'b0;
    int          pend_fault, exp_fault;
    int          pend_paddr, exp_paddr;
    string       pend_tag, exp_tag;
    int          rdq [$];
    string       rtq [$];

    task automatic model_walk(input logic [33:0] va, input bit wr, input logic [17:0] dbr);
        int a; logic [35:0] e; logic [35:0] d; logic [35:0] p;
        a = ({dbr, 6'b0} + va[33:26]) & 24'hFFFFFF;
        rdq.push_back(a); rtq.push_back("R2");
        e = rdm(a);
        if (!e[35]) begin cnt = 2; pend_fault = 1; pend_paddr = 0; pend_tag = "R3"; return; end
        a = ({e[13:0], 10'b0} + va[25:16]) & 24'hFFFFFF;
        rdq.push_back(a); rtq.push_back("R4");
        d = rdm(a);
        cnt = 4; pend_paddr = 0;
        if (!d[35]) begin pend_fault = 1; pend_tag = "R4"; return; end
        if (wr ? !d[33] : !d[34]) begin pend_fault = 2; pend_tag = "R5"; return; end
        if (int'(va[15:6]) >= int'(d[28:18])) begin pend_fault = 2; pend_tag = "R6"; return; end
        a = ({d[17:0], 6'b0} + va[15:10]) & 24'hFFFFFF;
        rdq.push_back(a); rtq.push_back("R7");
        p = rdm(a);
        cnt = 6;
        if (!p[35]) begin pend_fault = 3; pend_tag = "R7"; return; end
        pend_fault = 0; pend_tag = "R8";
        pend_paddr = ({p[13:0], 10'b0} + va[9:0]) & 24'hFFFFFF;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_ready = 1'b1; exp_done = 1'b0; pending = 1'b0; cnt = 0;
        end else begin
            bit was_ready;
            was_ready = exp_ready;
            exp_done = 1'b0;
            if (pending) begin
                cnt--;
                if (cnt == 0) begin
                    exp_done = 1'b1; pending = 1'b0; exp_ready = 1'b1;
                    exp_fault = pend_fault; exp_paddr = pend_paddr; exp_tag = pend_tag;
                end
            end
            if (was_ready && req_valid) begin
                model_walk(req_vaddr, req_write, dbr_ptr);
                pending = 1'b1; exp_ready = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(req_ready == exp_ready, "R1/R11 ready", req_ready, exp_ready);
            chk(rsp_done == exp_done, "R9 done", rsp_done, exp_done);
            if (rsp_done && exp_done) begin
                chk(rsp_fault == exp_fault[1:0], {exp_tag, " fault"}, rsp_fault, exp_fault);
                chk(rsp_paddr == exp_paddr[23:0], {exp_tag, " paddr"}, rsp_paddr, exp_paddr);
            end
            if (mem_rd) begin
                if (rdq.size() == 0) chk(1'b0, "R11 unexpected read", mem_addr, 0);
                else begin
                    int ea; string et;
                    ea = rdq.pop_front(); et = rtq.pop_front();
                    chk(mem_addr == ea[23:0], {et, " read address"}, mem_addr, ea);
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_done();
        int n = 0;
        while (!rsp_done && n < 40) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic issue(input logic [33:0] va, input bit wr);
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
    endtask

    function automatic logic [33:0] mkva(input int seg, input int pg, input int wd);
        return {seg[17:0], pg[5:0], wd[9:0]};
    endfunction

    localparam int SA = 18'h00403, SB = 18'h00404, SC = 18'h00405;
    localparam int SD = 18'h00406, SE = 18'h00407, SF = 18'h00800;

    initial begin
        // descriptor-segment page table at 0x4000
        mem[32'h4001] = pte(14'h0020);          // descriptor page -> 0x8000
        // descriptors
        mem[32'h8003] = dsc(1, 1, 1, 1024, 18'h00400);   // SA: full, rw
        mem[32'h8004] = dsc(1, 1, 0, 1024, 18'h00401);   // SB: read only
        mem[32'h8005] = dsc(1, 0, 1, 1024, 18'h00400);   // SC: write only
        mem[32'h8006] = dsc(1, 1, 1, 2,    18'h00400);   // SD: 128 words
        mem[32'h8007] = dsc(0, 0, 0, 0,    18'h00400);   // SE: absent
        // page tables
        mem[32'h10000] = pte(14'h0011);
        mem[32'h10005] = pte(14'h0155);
        mem[32'h1003F] = pte(14'h3FFF);
        mem[32'h10040] = pte(14'h0200);

        repeat (3) @(negedge clk);
        n_chk++;
        if (!(req_ready == 1'b1 && rsp_done == 1'b0 && mem_rd == 1'b0)) begin
            n_bad++;
            $display("FAIL R10 reset state actual=%b%b%b expected=100",
                     req_ready, rsp_done, mem_rd);
        end
        @(negedge clk) rst_n = 1'b1;

        issue(mkva(SA, 5, 10'h123), 1'b0);     // R8 read hit
        issue(mkva(SA, 5, 10'h000), 1'b1);     // R8 write hit
        issue(mkva(SA, 63, 10'h3FF), 1'b0);    // R8 top offset
        issue(mkva(SA, 6, 10'h001), 1'b0);     // R7 page absent
        issue(mkva(SF, 0, 10'h000), 1'b0);     // R3 descriptor page absent
        issue(mkva(SE, 0, 10'h000), 1'b1);     // R4 absent beats no permission
        issue(mkva(SB, 0, 10'h010), 1'b0);     // R5 read allowed
        issue(mkva(SB, 0, 10'h010), 1'b1);     // R5 write refused
        issue(mkva(SC, 5, 10'h010), 1'b0);     // R5 read refused
        issue(mkva(SC, 5, 10'h010), 1'b1);     // R5 write allowed
        issue(mkva(SD, 0, 10'h07F), 1'b0);     // R6 last word inside
        issue(mkva(SD, 0, 10'h080), 1'b0);     // R6 first word outside

        // R11: pulses during a busy walk are ignored
        @(negedge clk);
        req_vaddr = mkva(SA, 5, 10'h0AA); req_write = 1'b0; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_vaddr = mkva(SF, 0, 0);
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        wait_done();

        // R1: back-to-back, the second request taken in the done cycle's wake
        @(negedge clk);
        req_vaddr = mkva(SA, 63, 10'h001); req_write = 1'b0; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_vaddr = mkva(SB, 0, 10'h002);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();

        // R2: a different base pointer moves the first read
        dbr_ptr = 18'h00200;
        mem[32'h8001] = pte(14'h0020);
        issue(mkva(SA, 5, 10'h3C0), 1'b0);

        repeat (4) @(negedge clk);
        chk(rdq.size() == 0, "R11 reads outstanding", rdq.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule